// File: doc/BRIEF.md
# Stochastic Bit-Stream Probability Counter

This block turns a serial stream of random decisions into a binary code. An external comparator delivers one 0/1 result per sampling strobe, and each strobe is one trial. The block counts the ones across a fixed window of trials. When the window closes, it scales the count to a fine code of `FINE_W` bits, latches the code into an output register and pulses `code_valid` for one cycle. The counters clear at the same edge, so the next window's first trial can arrive in the very next cycle.

The window holds `2**LOG2_WIN` trials. The default is 2,048 trials, which gives an accurate average. A short window such as 64 or 128 trials converts faster and is less accurate. `start` abandons any partial window and begins counting from zero.

Top module: `stoch_prob_counter`

## Requirements
- R1: At the close of a window, `code` becomes min(N >> (LOG2_WIN-FINE_W), 2**FINE_W-1), where N is the number of ones counted in that window. If LOG2_WIN < FINE_W, N is shifted left by (FINE_W-LOG2_WIN) before the same saturation.
- R2: A window is exactly 2**LOG2_WIN trials. With LOG2_WIN=4 and FINE_W=4, windows of 4, 8 and 12 ones out of 16 give codes 4 (0100), 8 (1000) and 12 (1100).
- R3: `code_valid` is high for exactly one cycle: the cycle after the edge that counts the final trial of a window. It is low at every other time. `code` takes its new value in that same cycle.
- R4: Outside a `code_valid` cycle, `code` keeps its previous value.
- R5: A cycle with `bit_valid` low is not a trial. `bit_in` has no effect in such a cycle.
- R6: A cycle with `start` high discards the partial window and that cycle's `bit_in`, whatever the value of `bit_valid`. It produces no `code_valid`. The next trial is the first trial of a fresh window.
- R7: The trial that follows the last trial of a window is counted in the next window, even when it arrives in the very next cycle.
- R8: A window of all ones saturates `code` to 2**FINE_W-1.
- R9: While `rst` is high (synchronous, active high), `code` is 0, `code_valid` is 0 and the partial count is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Abort the current window and restart from zero |
| bit_valid | input | 1 | Marks `bit_in` as one trial |
| bit_in | input | 1 | Comparator decision |
| code | output | FINE_W | Registered scaled fraction of ones |
| code_valid | output | 1 | One-cycle pulse when `code` is updated |

## Verification
Two small configurations are swept over every possible ones count per window. The first uses 16 trials with no scaling and shows the exact count and the saturation step. The second uses 64 trials with a one-bit shift and shows that the result is scaled down and saturated. The ones are spread in a permuted order, and idle cycles carrying a high `bit_in` are inserted between trials, so a miscounted idle cycle or an off-by-one window length shifts the result. Back-to-back windows separate a counter that clears cleanly at the boundary from one that loses or duplicates the boundary trial. Restarts in mid-window and on the final trial show that partial counts are discarded and that no pulse leaks out.

// File: rtl/stoch_prob_counter.sv
module stoch_prob_counter #(
  parameter int LOG2_WIN = 11,
  parameter int FINE_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic [FINE_W-1:0] code,
  output logic              code_valid
);
  localparam int CW = LOG2_WIN + 1;

  logic [LOG2_WIN-1:0] trial_q;
  logic [CW-1:0]       ones_q;
  logic [CW-1:0]       ones_next;
  logic [FINE_W:0]     scaled;
  logic [FINE_W-1:0]   sat;
  logic                last;

  assign ones_next = ones_q + CW'(bit_in);
  assign last      = bit_valid && (trial_q == {LOG2_WIN{1'b1}});

  generate
    if (LOG2_WIN >= FINE_W) begin : g_down
      localparam int SH = LOG2_WIN - FINE_W;
      logic [CW-1:0] shr;
      assign shr    = ones_next >> SH;
      assign scaled = shr[FINE_W:0];
    end else begin : g_up
      assign scaled = {ones_next, {(FINE_W - LOG2_WIN){1'b0}}};
    end
  endgenerate

  assign sat = scaled[FINE_W] ? {FINE_W{1'b1}} : scaled[FINE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_q    <= '0;
      ones_q     <= '0;
      code       <= '0;
      code_valid <= 1'b0;
    end else begin
      code_valid <= 1'b0;
      if (start) begin
        trial_q <= '0;
        ones_q  <= '0;
      end else if (bit_valid) begin
        trial_q <= trial_q + 1'b1;
        if (last) begin
          ones_q     <= '0;
          code       <= sat;
          code_valid <= 1'b1;
        end else begin
          ones_q <= ones_next;
        end
      end
    end
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    code_valid |=> !code_valid);

  a_r4_code_hold: assert property (@(posedge clk) disable iff (rst)
    !code_valid |-> $stable(code));

  a_r5_idle_no_count: assert property (@(posedge clk) disable iff (rst)
    (!bit_valid && !start) |=> ($stable(trial_q) && $stable(ones_q) && !code_valid));

  a_r6_start_no_pulse: assert property (@(posedge clk) disable iff (rst)
    start |=> (!code_valid && trial_q == '0 && ones_q == '0));

  a_r2_ones_bounded: assert property (@(posedge clk) disable iff (rst)
    ones_q <= CW'(trial_q));
endmodule

// File: tb/stoch_prob_counter_test.sv
module stoch_prob_counter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_a = 0, bv_a = 0, bi_a = 0;
  logic st_b = 0, bv_b = 0, bi_b = 0;
  logic [3:0] code_a;
  logic [4:0] code_b;
  logic cv_a, cv_b;

  int total = 0;
  int bad = 0;
  bit pend = 0;
  int pend_exp = 0;
  string pend_tag;
  int held[2] = '{0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  stoch_prob_counter #(.LOG2_WIN(4), .FINE_W(4)) uut (
    .clk(clk), .rst(rst), .start(st_a), .bit_valid(bv_a), .bit_in(bi_a),
    .code(code_a), .code_valid(cv_a));

  stoch_prob_counter #(.LOG2_WIN(6), .FINE_W(5)) uut_b (
    .clk(clk), .rst(rst), .start(st_b), .bit_valid(bv_b), .bit_in(bi_b),
    .code(code_b), .code_valid(cv_b));

  task automatic chk(int got, int exp, string req);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic drive(int which, bit s, bit v, bit b);
    int gv, gc;
    @(negedge clk);
    gv = (which == 1) ? int'(cv_b) : int'(cv_a);
    gc = (which == 1) ? int'(code_b) : int'(code_a);
    if (pend) begin
      chk(gv, 1, {pend_tag, " valid pulse (R3)"});
      chk(gc, pend_exp, pend_tag);
      held[which] = pend_exp;
      pend = 0;
    end else begin
      chk(gv, 0, "R3 stray pulse");
      chk(gc, held[which], "R4 code hold");
    end
    if (which == 1) begin st_b = s; bv_b = v; bi_b = b; end
    else begin st_a = s; bv_a = v; bi_a = b; end
  endtask

  task automatic window(int which, int k, bit gaps, string tag);
    int w  = (which == 1) ? 64 : 16;
    int lw = (which == 1) ? 6 : 4;
    int fw = (which == 1) ? 5 : 4;
    int e  = k >> (lw - fw);
    if (e > (1 << fw) - 1) e = (1 << fw) - 1;
    for (int i = 0; i < w; i++) begin
      if (gaps && (i % 3 == 1)) drive(which, 0, 0, 1);
      drive(which, 0, 1, ((i * 7) % w) < k);
    end
    pend = 1;
    pend_exp = e;
    pend_tag = tag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(int'(cv_a), 0, "R9 reset valid");
    chk(int'(code_a), 0, "R9 reset code");
    chk(int'(code_b), 0, "R9 reset code b");
    rst = 1'b0;

    // R1 / R8: exhaustive sweep, unscaled 16-trial window
    for (int k = 0; k <= 16; k++) begin
      window(0, k, k % 2 == 1, (k == 16) ? "R8 saturate" : "R1 sweep16");
      drive(0, 0, 0, 1);
    end
    // R1 / R5: exhaustive sweep, 64 trials scaled by one bit, idle gaps with bit_in high
    for (int k = 0; k <= 64; k++) begin
      window(1, k, k % 3 == 0, (k == 64) ? "R8 saturate b" : "R1 R5 sweep64");
      drive(1, 0, 0, 1);
    end

    // R2 / R7: back-to-back windows with no idle cycle between them
    window(0, 4, 0, "R2 R7 code4");
    window(0, 8, 0, "R2 R7 code8");
    window(0, 12, 0, "R2 R7 code12");
    drive(0, 0, 0, 0);
    drive(0, 0, 0, 0);

    // R6: abort mid-window; the start cycle carries a valid one that must be dropped
    for (int i = 0; i < 5; i++) drive(0, 0, 1, 1);
    drive(0, 1, 1, 1);
    window(0, 3, 0, "R6 restart mid");
    drive(0, 0, 0, 0);

    // R6: abort on what would be the final trial
    for (int i = 0; i < 15; i++) drive(0, 0, 1, 1);
    drive(0, 1, 1, 1);
    window(0, 16, 1, "R6 R8 restart last");
    drive(0, 0, 0, 0);
    drive(0, 0, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule